// File: doc/BRIEF.md
# Programmable Video Clock Divider Chain

This block derives a pixel-rate clock from a fast reference clock in two cascaded stages. The first stage divides by any integer N. Odd ratios are made by giving the low and high phases of each output period unequal lengths. The second stage divides the result by a power of two, 2^M. A bypass path in each stage handles a ratio of one, because a flop that toggles on every active cycle already divides by two. The output duty cycle does not have to be 50%, since a clock-conditioning stage further downstream restores it.

Every flop runs on the reference clock. The power-of-two stage does not use the first stage's output as a clock. It advances on a one-cycle enable that marks each rising edge of the first stage's output. Software writes N and M and pulses `load`. That load captures the new settings, restarts both counters and drives the output low. The hardware does not check the range of N or M. Alongside the divided clock, the block produces `rise_pulse`, which is high for one reference cycle on each rising edge of `clk_out`.

Top module: `vclk_div_chain`

## Requirements
- R1: With a captured N of 0 or 1 and M = 0, `clk_out` follows `clk_ref` and `rise_pulse` stays high in every cycle.
- R2: With a captured N of 0 or 1 and M ≥ 1, `clk_out` has a period of 2^M reference cycles and is high for 2^(M-1) of them.
- R3: With an even captured N ≥ 2 and M = 0, `clk_out` has a period of N cycles and is high for N/2 of them. N = 2 toggles the output on every cycle.
- R4: With an odd captured N ≥ 3 and M = 0, each period of N cycles is high for floor(N/2) cycles and low for ceil(N/2) cycles.
- R5: For every N from 1 to 20 and every M from 0 to 5, the spacing between successive `rise_pulse` assertions is N·2^M cycles. When N ≥ 2 or M ≥ 1, `clk_out` is high for floor(N/2) cycles of each period if M = 0, and for N·2^(M-1) cycles if M ≥ 1.
- R6: Outside full bypass, `rise_pulse` is high for exactly one cycle, and that cycle is the first cycle in which `clk_out` is high.
- R7: `n_val` and `m_sel` take effect only in a cycle where `load` is high. Changing them while `load` is low leaves the output period unchanged.
- R8: In the cycle after `load` (non-bypass settings), `clk_out` and `rise_pulse` are low. The first `rise_pulse` then comes no later than one new full period after the load edge.
- R9: After reset is released and before any load, the captured settings are N = 1 and M = 0, so the block is in full bypass: `rise_pulse` is high and `clk_out` follows `clk_ref`.
- R10: M codes 6 and 7 are accepted without a range check and give ratios of 64 and 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock; clocks every flop |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Captures `n_val`/`m_sel`, restarts counters, clears output |
| n_val | input | 8 | First-stage integer ratio N (0 behaves as 1) |
| m_sel | input | 3 | Second-stage exponent M, ratio 2^M |
| clk_out | output | 1 | Divided clock |
| rise_pulse | output | 1 | One-cycle pulse marking each rising edge of `clk_out` |

## Verification
The two events that can share a cycle are a `load` and a terminal count in one or both stages. A terminal count would toggle the output or raise `rise_pulse`. The scoreboard provokes this by reloading mid-period across all 120 (N, M) pairs and by changing the inputs without `load` while a stage is counting. In each case it judges that the cycle after the load shows a low `clk_out` with no pulse. It also judges that the next measured periods and high times match the new settings, or the old ones when `load` was absent. The remaining checks are full bypass, odd splits, and the unchecked exponent codes 6 and 7.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

  localparam int N_W = 8;
  localparam int M_W = 3;
  localparam int PC_W = (1 << M_W) - 1;

  // cycles spent low in one first-stage period (ceil), at least one
  function automatic int lo_half(input int n);
    return (n <= 1) ? 1 : (n + 1) / 2;
  endfunction

  // cycles spent high in one first-stage period (floor), at least one
  function automatic int hi_half(input int n);
    return (n <= 1) ? 1 : n / 2;
  endfunction

  // first-stage rising events per second-stage half period
  function automatic int post_half(input int m);
    return (m == 0) ? 1 : (1 << (m - 1));
  endfunction

endpackage

// File: rtl/vclk_rst_sync.sv
module vclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_s_n = stg_q[1];

endmodule

// File: rtl/vclk_prediv.sv
module vclk_prediv
  import vclk_pkg::*;
#(
  parameter int NW = N_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] n_new,
  input  logic [NW-1:0] n_cfg,
  output logic          byp,
  output logic          stg_q,
  output logic          rise,
  output logic          adv_en,
  output logic [NW-1:0] cnt_o
);

  logic          q_r, q_n;
  logic [NW-1:0] cnt_r, cnt_n;

  assign byp    = (n_cfg <= NW'(1));
  assign rise   = !load && !byp && (cnt_r == '0) && !q_r;
  assign adv_en = !load && (byp || rise);

  always_comb begin
    q_n   = q_r;
    cnt_n = cnt_r;
    if (load) begin
      q_n   = 1'b0;
      cnt_n = NW'(lo_half(int'(n_new)) - 1);
    end else if (!byp) begin
      if (cnt_r == '0) begin
        q_n   = ~q_r;
        cnt_n = q_r ? NW'(lo_half(int'(n_cfg)) - 1)
                    : NW'(hi_half(int'(n_cfg)) - 1);
      end else begin
        cnt_n = cnt_r - NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= 1'b0;
      cnt_r <= '0;
    end else begin
      q_r   <= q_n;
      cnt_r <= cnt_n;
    end
  end

  assign stg_q = q_r;
  assign cnt_o = cnt_r;

endmodule

// File: rtl/vclk_postdiv.sv
module vclk_postdiv
  import vclk_pkg::*;
#(
  parameter int MW = M_W,
  localparam int CW = (1 << MW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv_en,
  input  logic [MW-1:0] m_new,
  input  logic [MW-1:0] m_cfg,
  output logic          byp,
  output logic          stg_q,
  output logic          rise,
  output logic [CW-1:0] cnt_o
);

  logic          q_r, q_n;
  logic [CW-1:0] cnt_r, cnt_n;

  assign byp  = (m_cfg == '0);
  assign rise = !load && !byp && adv_en && (cnt_r == '0) && !q_r;

  always_comb begin
    q_n   = q_r;
    cnt_n = cnt_r;
    if (load) begin
      q_n   = 1'b0;
      cnt_n = CW'(post_half(int'(m_new)) - 1);
    end else if (!byp && adv_en) begin
      if (cnt_r == '0) begin
        q_n   = ~q_r;
        cnt_n = CW'(post_half(int'(m_cfg)) - 1);
      end else begin
        cnt_n = cnt_r - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= 1'b0;
      cnt_r <= '0;
    end else begin
      q_r   <= q_n;
      cnt_r <= cnt_n;
    end
  end

  assign stg_q = q_r;
  assign cnt_o = cnt_r;

endmodule

// File: rtl/vclk_div_chain.sv
module vclk_div_chain
  import vclk_pkg::*;
#(
  parameter int NW    = N_W,
  parameter int MW    = M_W,
  parameter int RST_N = 1,
  parameter int RST_M = 0,
  localparam int CW   = (1 << MW) - 1
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] n_val,
  input  logic [MW-1:0] m_sel,
  output logic          clk_out,
  output logic          rise_pulse
);

  logic          rst_s_n;
  logic [NW-1:0] n_cfg, n_cfg_n;
  logic [MW-1:0] m_cfg, m_cfg_n;
  logic          pre_byp, pre_q, pre_rise, pre_en;
  logic          post_byp, post_q, post_rise;
  logic [NW-1:0] pre_cnt;
  logic [CW-1:0] post_cnt;
  logic          rise_q, rise_n;
  logic          byp_all;

  vclk_rst_sync u_rst (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // settings change only under the load strobe
  always_comb begin
    n_cfg_n = n_cfg;
    m_cfg_n = m_cfg;
    if (load) begin
      n_cfg_n = n_val;
      m_cfg_n = m_sel;
    end
  end

  vclk_prediv #(.NW(NW)) u_pre (
    .clk    (clk_ref),
    .rst_n  (rst_s_n),
    .load   (load),
    .n_new  (n_val),
    .n_cfg  (n_cfg),
    .byp    (pre_byp),
    .stg_q  (pre_q),
    .rise   (pre_rise),
    .adv_en (pre_en),
    .cnt_o  (pre_cnt)
  );

  vclk_postdiv #(.MW(MW)) u_post (
    .clk    (clk_ref),
    .rst_n  (rst_s_n),
    .load   (load),
    .adv_en (pre_en),
    .m_new  (m_sel),
    .m_cfg  (m_cfg),
    .byp    (post_byp),
    .stg_q  (post_q),
    .rise   (post_rise),
    .cnt_o  (post_cnt)
  );

  assign byp_all = pre_byp && post_byp;
  assign rise_n  = !load && (post_byp ? pre_rise : post_rise);

  always_ff @(posedge clk_ref or negedge rst_s_n) begin
    if (!rst_s_n) begin
      n_cfg  <= NW'(RST_N);
      m_cfg  <= MW'(RST_M);
      rise_q <= 1'b0;
    end else begin
      n_cfg  <= n_cfg_n;
      m_cfg  <= m_cfg_n;
      rise_q <= rise_n;
    end
  end

  assign clk_out    = byp_all ? clk_ref : (post_byp ? pre_q : post_q);
  assign rise_pulse = byp_all ? 1'b1 : rise_q;

endmodule

// File: rtl/vclk_div_chain_chk.sv
module vclk_div_chain_chk
  import vclk_pkg::*;
#(
  parameter int NW = N_W,
  parameter int MW = M_W,
  localparam int CW = (1 << MW) - 1
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          load,
  input logic          clk_out,
  input logic          rise_pulse,
  input logic          byp_all,
  input logic          pre_byp,
  input logic          post_byp,
  input logic [NW-1:0] n_cfg,
  input logic [MW-1:0] m_cfg,
  input logic [NW-1:0] pre_cnt,
  input logic [CW-1:0] post_cnt
);

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rise_pulse && !byp_all) |=> (!rise_pulse || byp_all));

  p_pulse_high_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rise_pulse && !byp_all) |-> clk_out);

  p_load_clear_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    load |=> (byp_all || (!clk_out && !rise_pulse)));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !load |=> ($stable(n_cfg) && $stable(m_cfg)));

  p_pre_range_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pre_byp |-> (int'(pre_cnt) <= lo_half(int'(n_cfg)) - 1));

  p_post_range_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !post_byp |-> (int'(post_cnt) <= post_half(int'(m_cfg)) - 1));

endmodule

bind vclk_div_chain vclk_div_chain_chk #(.NW(NW), .MW(MW)) u_chk (
  .clk        (clk_ref),
  .rst_s_n    (rst_s_n),
  .load       (load),
  .clk_out    (clk_out),
  .rise_pulse (rise_pulse),
  .byp_all    (byp_all),
  .pre_byp    (pre_byp),
  .post_byp   (post_byp),
  .n_cfg      (n_cfg),
  .m_cfg      (m_cfg),
  .pre_cnt    (pre_cnt),
  .post_cnt   (post_cnt)
);

// File: tb/test_vclk_div_chain.sv
`timescale 1ns/100ps
module test_vclk_div_chain;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] n_val = 8'd0;
  logic [2:0] m_sel = 3'd0;
  logic       clk_out, rise_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int    q_per[$];
  int    q_hi[$];
  string q_req[$];

  always #2.5 clk = ~clk;

  vclk_div_chain i_vclk_div_chain (
    .clk_ref    (clk),
    .rst_n      (rst_n),
    .load       (load),
    .n_val      (n_val),
    .m_sel      (m_sel),
    .clk_out    (clk_out),
    .rise_pulse (rise_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measure period and high time between rising pulses
  int  m_cyc = 0;
  int  m_hi  = 0;
  bit  m_seen = 0;
  always @(negedge clk) begin
    if (!rst_n || load) begin
      m_seen = 0; m_cyc = 0; m_hi = 0;
    end else if (rise_pulse) begin
      if (m_seen && q_per.size() > 0) begin
        int    ep, eh;
        string rq;
        ep = q_per.pop_front();
        eh = q_hi.pop_front();
        rq = q_req.pop_front();
        check(m_cyc == ep, {rq, " period"}, m_cyc, ep);
        check(m_hi == eh,  {rq, " high"},   m_hi,  eh);
      end
      m_seen = 1; m_cyc = 1; m_hi = clk_out ? 1 : 0;
    end else begin
      m_cyc++;
      if (clk_out) m_hi++;
    end
  end

  function automatic int exp_hi(input int n, input int m);
    if (n <= 1 && m == 0) return 0;
    if (m == 0) return n / 2;
    return (n <= 1 ? 1 : n) * (1 << (m - 1));
  endfunction

  task automatic push(input int per, input int hi, input string req, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      q_per.push_back(per); q_hi.push_back(hi); q_req.push_back(req);
    end
  endtask

  task automatic drain();
    int lim = 0;
    while (q_per.size() > 0 && lim < 20000) begin
      @(negedge clk); lim++;
    end
    check(q_per.size() == 0, "scoreboard drain", q_per.size(), 0);
    q_per.delete(); q_hi.delete(); q_req.delete();
  endtask

  // apply settings; check clear and first-rise latency (R8)
  task automatic apply(input int n, input int m);
    int per, cnt;
    bit byp;
    per = (n <= 1 ? 1 : n) * (1 << m);
    byp = (n <= 1) && (m == 0);
    @(posedge clk); #1;
    load = 1'b1; n_val = 8'(n); m_sel = 3'(m);
    @(posedge clk); #1;
    load = 1'b0;
    @(negedge clk);
    if (!byp) begin
      check(!clk_out, "R8 clk_out low after load", clk_out, 0);
      check(!rise_pulse, "R8 rise_pulse low after load", rise_pulse, 0);
    end
    cnt = 1;
    while (!rise_pulse && cnt <= per + 2) begin
      @(negedge clk); cnt++;
    end
    check(cnt >= 1 && cnt <= per, "R8 first rise latency", cnt, per);
  endtask

  function automatic string tag(input int n, input int m);
    if (n <= 1 && m == 0) return "R1";
    if (n <= 1) return "R2";
    if (m == 0) return (n % 2 == 0) ? "R3" : "R4";
    return "R5";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R9: reset state is full bypass
    #1;
    check(rise_pulse == 1'b1, "R9 rise_pulse after reset", rise_pulse, 1);
    check(clk_out == 1'b1, "R9 clk_out high in clk_ref high phase", clk_out, 1);
    @(negedge clk); #1;
    check(clk_out == 1'b0, "R9 clk_out low in clk_ref low phase", clk_out, 0);

    // R1: N=0 behaves as N=1 in full bypass
    apply(0, 0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check(clk_out == 1'b1 && rise_pulse, "R1 follow clk_ref high", clk_out, 1);
      @(negedge clk); #1;
      check(clk_out == 1'b0 && rise_pulse, "R1 follow clk_ref low", clk_out, 0);
    end

    // R2: N=0 with M=3
    apply(0, 3);
    push(8, 4, "R2 n0", 2);
    drain();

    // R5 sweep (also R3, R4, R1, R2 cases)
    for (int n = 1; n <= 20; n++) begin
      for (int m = 0; m <= 5; m++) begin
        int per;
        per = n * (1 << m);
        apply(n, m);
        push(per, exp_hi(n, m), {tag(n, m), " R5 sweep"}, 2);
        drain();
      end
    end

    // R7: input change without load has no effect
    apply(5, 1);
    @(posedge clk); #1;
    n_val = 8'd3; m_sel = 3'd4;
    push(10, 5, "R7 no-load change", 3);
    drain();

    // R7/R8: reload mid-period
    apply(7, 2);
    repeat (9) @(posedge clk);
    apply(9, 0);
    push(9, 4, "R8 reload mid-period", 2);
    drain();

    // R10: unchecked exponent codes
    apply(2, 6);
    push(128, 64, "R10 m6", 1);
    drain();
    apply(1, 7);
    push(128, 64, "R10 m7", 1);
    drain();

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule